// File: doc/BRIEF.md
# Edge-Change Interrupt Controller

This block watches a bank of input lines (24 by default) for level changes and turns selected changes into a single interrupt request. Each channel has its own rising-sensitivity bit and falling-sensitivity bit. Two global enables in the control register gate the whole rising class and the whole falling class. The inputs pass through a synchronizer before the edge comparison, so asynchronous pins can be connected directly.

A qualifying change sets a sticky edge flag. If another qualifying change arrives while that flag is still set, a sticky overflow flag is set as well. The interrupt line is driven from these two flags, each with its own enable, and is then gated by a master enable. Software reaches everything through a byte-wide register port. It programs the masks and the control byte, reads a status byte, and acknowledges events by writing command bits to a clear register. Reads take no action; read data appears one clock after the address.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Reading address 0x06 returns the constant 0x27.
- R2: Rising masks sit at addresses 0x18, 0x19 and 0x1A, and falling masks at 0x20, 0x21 and 0x22. Byte k covers channels 8k to 8k+7, with bit 0 as the lowest channel. The control byte sits at 0x15 with five defined bits, and its upper three bits read as 0. All of these read back what was written.
- R3: A 0-to-1 change on a channel sets the edge flag (status bit 0, address 0x14) when the channel's rising mask bit and the global rising enable (control bit 3) are both 1.
- R4: A 1-to-0 change on a channel sets the edge flag when the channel's falling mask bit and the global falling enable (control bit 4) are both 1.
- R5: A change on a channel whose mask bit for that direction is 0, or whose global enable for that direction is 0, leaves the edge flag unchanged.
- R6: A qualifying change while the edge flag is already set sets the overflow flag. The overflow flag stays set until a write to address 0x07 with bit 2 set, and clearing the edge flag does not clear it.
- R7: A write to address 0x07 with bit 3 set clears the edge flag. Writing 0x0C clears both flags in one write.
- R8: If a qualifying change is latched in the same cycle as a clear of the edge flag, the edge flag remains set.
- R9: irq_o is a register. It equals master enable (control bit 2) AND ((edge flag AND edge enable, control bit 0) OR (overflow flag AND overflow enable, control bit 1)), evaluated on the state of the previous cycle. Status bit 2 reads the current value of irq_o.
- R10: After a write of 0x00 to the control byte, irq_o is low from the second clock after the write onward.
- R11: A synchronous active-high reset clears every mask, the control byte, both flags, irq_o and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_CH | Monitored input lines, asynchronous |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 6 | Register address for both reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, valid one clock after reg_addr |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The bench times a clear command so that it lands in the same cycle a new edge is latched. A design that gives the clear priority would lose that event and read the flag back as 0. It raises a second edge before acknowledging the first and checks that the interrupt survives an edge-only clear. A design that forgot the overflow path, or cleared both flags with either bit, would drop irq_o early. It toggles channels that have only the mask bit set, or only the global enable set, and expects silence; a design that ignored either gate would raise the edge flag. A cycle-level model also compares irq_o and read data on every clock, which catches any extra or missing pipeline stage.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_ID     = 6'h06;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 6'h07;
  localparam logic [ADDR_W-1:0] A_STATUS = 6'h14;
  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h15;
  localparam logic [ADDR_W-1:0] A_RISE   = 6'h18;
  localparam logic [ADDR_W-1:0] A_FALL   = 6'h20;

  localparam logic [7:0] CHIP_ID = 8'h27;

  // clear command bit positions
  localparam int CLR_EDGE = 3;
  localparam int CLR_OVF  = 2;

  // control byte, bit 4 down to bit 0
  typedef struct packed {
    logic g_fall;
    logic g_rise;
    logic master;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] s,
  input  logic [W-1:0] rise_mask,
  input  logic [W-1:0] fall_mask,
  input  logic         g_rise,
  input  logic         g_fall,
  output logic         hit
);
  logic [W-1:0] prev;
  logic [W-1:0] rise_v, fall_v;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= s;
  end

  always_comb begin
    rise_v = s & ~prev & rise_mask & {W{g_rise}};
    fall_v = ~s & prev & fall_mask & {W{g_fall}};
    hit    = |(rise_v | fall_v);
  end
endmodule

// File: rtl/edge_flags.sv
module edge_flags
  import edge_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hit,
  input  logic  clr_edge,
  input  logic  clr_ovf,
  input  ctrl_t ctrl,
  output logic  edge_flag,
  output logic  ovf_flag,
  output logic  irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_flag <= 1'b0;
      ovf_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      // a new edge wins over a clear issued in the same cycle
      edge_flag <= hit | (edge_flag & ~clr_edge);
      ovf_flag  <= (hit & edge_flag) | (ovf_flag & ~clr_ovf);
      irq       <= ctrl.master &
                   ((edge_flag & ctrl.edge_ie) | (ovf_flag & ctrl.ovf_ie));
    end
  end
endmodule

// File: rtl/edge_regs.sv
module edge_regs
  import edge_irq_pkg::*;
#(
  parameter int W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              edge_flag,
  input  logic              irq,
  output logic [W-1:0]      rise_mask,
  output logic [W-1:0]      fall_mask,
  output ctrl_t             ctrl,
  output logic              clr_edge,
  output logic              clr_ovf,
  output logic [7:0]        rdata
);
  localparam int LANES = W / 8;

  logic [LANES-1:0][7:0] rise_b, fall_b;
  logic [7:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_b <= '0;
      fall_b <= '0;
      ctrl   <= '0;
    end else if (wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (addr == A_RISE + ADDR_W'(i)) rise_b[i] <= wdata;
        if (addr == A_FALL + ADDR_W'(i)) fall_b[i] <= wdata;
      end
      if (addr == A_CTRL) ctrl <= wdata[4:0];
    end
  end

  assign rise_mask = rise_b;
  assign fall_mask = fall_b;
  assign clr_edge  = wr && (addr == A_CLEAR) && wdata[CLR_EDGE];
  assign clr_ovf   = wr && (addr == A_CLEAR) && wdata[CLR_OVF];

  always_comb begin
    rd_next = 8'h00;
    if (addr == A_ID)     rd_next = CHIP_ID;
    if (addr == A_STATUS) rd_next = {5'b0, irq, 1'b0, edge_flag};
    if (addr == A_CTRL)   rd_next = {3'b0, ctrl};
    for (int i = 0; i < LANES; i++) begin
      if (addr == A_RISE + ADDR_W'(i)) rd_next = rise_b[i];
      if (addr == A_FALL + ADDR_W'(i)) rd_next = fall_b[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int N_CH        = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   pin_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_o
);
  logic [N_CH-1:0] pin_s, rise_mask, fall_mask;
  ctrl_t ctrl_q;
  logic  hit, clr_edge, clr_ovf, edge_flag, ovf_flag;

  edge_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  edge_detect #(.W(N_CH)) u_det (
    .clk(clk), .rst(rst), .s(pin_s),
    .rise_mask(rise_mask), .fall_mask(fall_mask),
    .g_rise(ctrl_q.g_rise), .g_fall(ctrl_q.g_fall), .hit(hit)
  );

  edge_flags u_flags (
    .clk(clk), .rst(rst), .hit(hit),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf), .ctrl(ctrl_q),
    .edge_flag(edge_flag), .ovf_flag(ovf_flag), .irq(irq_o)
  );

  edge_regs #(.W(N_CH)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .edge_flag(edge_flag), .irq(irq_o),
    .rise_mask(rise_mask), .fall_mask(fall_mask), .ctrl(ctrl_q),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf), .rdata(reg_rdata)
  );
endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [5:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       irq_o,
  input logic [4:0] ctrl,
  input logic       edge_flag,
  input logic       ovf_flag,
  input logic       hit
);
  AST_ID_CONST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_addr) == 6'h06) |-> reg_rdata == 8'h27); // R1

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && !edge_flag && !ovf_flag)); // R11

  AST_IRQ_MASTER: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl[2])); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(reg_wr && reg_addr == 6'h07 && reg_wdata[2])) |=> ovf_flag); // R6

  AST_EDGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    hit |=> edge_flag); // R8

  AST_CTRL_OFF: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 6'h15 && reg_wdata == 8'h00) |=> ##1 !irq_o); // R10
endmodule

bind edge_irq_ctrl edge_irq_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
  .ctrl(ctrl_q), .edge_flag(edge_flag), .ovf_flag(ovf_flag), .hit(hit)
);

// File: tb/sim_edge_irq_ctrl.sv
`timescale 1ns/1ps
module sim_edge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pin_in = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  edge_irq_ctrl u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [23:0] p_q[$];
  logic [23:0] m_rmask = '0, m_fmask = '0;
  logic [4:0]  m_ctrl = '0;
  bit          m_edge = 0, m_ovf = 0, m_irq = 0;
  logic [7:0]  m_rd = '0;

  function automatic logic [7:0] lane(input logic [23:0] v, input int k);
    return v[8*k +: 8];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      p_q = '{24'h0, 24'h0, 24'h0};
      m_rmask = '0; m_fmask = '0; m_ctrl = '0;
      m_edge = 0; m_ovf = 0; m_irq = 0; m_rd = '0;
    end else begin
      logic [23:0] now_v, old_v;
      bit ev, ce, co, n_edge, n_ovf, n_irq;
      logic [7:0] n_rd;
      now_v = p_q[1];
      old_v = p_q[2];
      ev = 0;
      for (int c = 0; c < 24; c++) begin
        if (now_v[c] && !old_v[c] && m_rmask[c] && m_ctrl[3]) ev = 1;
        if (!now_v[c] && old_v[c] && m_fmask[c] && m_ctrl[4]) ev = 1;
      end
      ce = reg_wr && reg_addr == 6'h07 && reg_wdata[3];
      co = reg_wr && reg_addr == 6'h07 && reg_wdata[2];
      n_edge = ev || (m_edge && !ce);
      n_ovf  = (ev && m_edge) || (m_ovf && !co);
      n_irq  = m_ctrl[2] && ((m_edge && m_ctrl[0]) || (m_ovf && m_ctrl[1]));
      case (reg_addr)
        6'h06: n_rd = 8'h27;
        6'h14: n_rd = {5'b0, m_irq, 1'b0, m_edge};
        6'h15: n_rd = {3'b0, m_ctrl};
        6'h18, 6'h19, 6'h1A: n_rd = lane(m_rmask, int'(reg_addr) - 'h18);
        6'h20, 6'h21, 6'h22: n_rd = lane(m_fmask, int'(reg_addr) - 'h20);
        default: n_rd = 8'h00;
      endcase
      if (reg_wr) begin
        if (reg_addr == 6'h15) m_ctrl = reg_wdata[4:0];
        for (int k = 0; k < 3; k++) begin
          if (int'(reg_addr) == 'h18 + k) m_rmask[8*k +: 8] = reg_wdata;
          if (int'(reg_addr) == 'h20 + k) m_fmask[8*k +: 8] = reg_wdata;
        end
      end
      m_edge = n_edge; m_ovf = n_ovf; m_irq = n_irq; m_rd = n_rd;
      p_q.push_front(pin_in);
      p_q.pop_back();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(irq_o == m_irq, "R9 model irq", irq_o, m_irq);
      chk(reg_rdata == m_rd, "R2 model rdata", reg_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_pin(input int c, input bit v);
    @(negedge clk);
    pin_in[c] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b0, "R11 irq in reset", irq_o, 0);
    chk(reg_rdata == 8'h00, "R11 rdata in reset", reg_rdata, 0);
    rst = 1'b0;
    rd(6'h14, d); chk(d == 8'h00, "R11 status after reset", d, 0);
    rd(6'h19, d); chk(d == 8'h00, "R11 rise mask after reset", d, 0);
    rd(6'h15, d); chk(d == 8'h00, "R11 ctrl after reset", d, 0);

    rd(6'h06, d); chk(d == 8'h27, "R1 id", d, 8'h27);

    wr(6'h18, 8'hA5); wr(6'h19, 8'h3C); wr(6'h1A, 8'h81);
    wr(6'h20, 8'h5A); wr(6'h21, 8'hC3); wr(6'h22, 8'h18);
    rd(6'h19, d); chk(d == 8'h3C, "R2 rise lane1", d, 8'h3C);
    rd(6'h1A, d); chk(d == 8'h81, "R2 rise lane2", d, 8'h81);
    rd(6'h20, d); chk(d == 8'h5A, "R2 fall lane0", d, 8'h5A);
    rd(6'h22, d); chk(d == 8'h18, "R2 fall lane2", d, 8'h18);
    wr(6'h15, 8'hFF);
    rd(6'h15, d); chk(d == 8'h1F, "R2 ctrl upper bits", d, 8'h1F);

    // rising on ch0 only, falling on ch8 only
    wr(6'h15, 8'h00);
    wr(6'h18, 8'h01); wr(6'h19, 8'h00); wr(6'h1A, 8'h00);
    wr(6'h20, 8'h00); wr(6'h21, 8'h01); wr(6'h22, 8'h00);
    wr(6'h15, 8'h0D);

    set_pin(0, 1);
    rd(6'h14, d); chk(d == 8'h05, "R3 rising ch0 status", d, 8'h05);
    chk(irq_o == 1'b1, "R9 irq on edge", irq_o, 1);
    wr(6'h07, 8'h08); repeat (2) @(negedge clk);
    rd(6'h14, d); chk(d == 8'h00, "R7 edge cleared", d, 0);

    set_pin(1, 1);
    rd(6'h14, d); chk(d == 8'h00, "R5 unmasked channel ignored", d, 0);
    set_pin(8, 1);
    set_pin(8, 0);
    rd(6'h14, d); chk(d == 8'h00, "R5 global fall off ignored", d, 0);

    wr(6'h15, 8'h1D);
    set_pin(8, 1);
    rd(6'h14, d); chk(d == 8'h00, "R5 rising on fall-only channel", d, 0);
    set_pin(8, 0);
    rd(6'h14, d); chk(d == 8'h05, "R4 falling ch8 status", d, 8'h05);
    wr(6'h07, 8'h0C); repeat (2) @(negedge clk);
    chk(irq_o == 1'b0, "R7 both cleared", irq_o, 0);

    // overflow only raises the line
    wr(6'h15, 8'h0E);
    set_pin(0, 0);
    set_pin(0, 1);
    chk(irq_o == 1'b0, "R6 single edge no overflow irq", irq_o, 0);
    set_pin(0, 0);
    set_pin(0, 1);
    chk(irq_o == 1'b1, "R6 second edge overflow irq", irq_o, 1);
    wr(6'h07, 8'h08); repeat (2) @(negedge clk);
    chk(irq_o == 1'b1, "R6 overflow survives edge clear", irq_o, 1);
    wr(6'h07, 8'h04); repeat (2) @(negedge clk);
    chk(irq_o == 1'b0, "R6 overflow cleared", irq_o, 0);

    // same-cycle clear and edge
    wr(6'h15, 8'h0D);
    set_pin(0, 0);
    set_pin(0, 1);
    set_pin(0, 0);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 6'h07; reg_wdata = 8'h08;
    @(negedge clk); reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rd(6'h14, d); chk(d[0] == 1'b1, "R8 edge kept over clear", d[0], 1);

    chk(irq_o == 1'b1, "R10 irq before disable", irq_o, 1);
    wr(6'h15, 8'h00); @(negedge clk);
    chk(irq_o == 1'b0, "R10 ctrl zero disables", irq_o, 0);
    wr(6'h15, 8'h03); repeat (2) @(negedge clk);
    chk(irq_o == 1'b0, "R9 no master no irq", irq_o, 0);
    wr(6'h15, 8'h06); repeat (2) @(negedge clk);
    chk(irq_o == 1'b1, "R9 overflow path with master", irq_o, 1);
    rd(6'h14, d); chk(d[2] == 1'b1, "R9 status mirrors irq", d[2], 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule